// File: doc/BRIEF.md
# Clock Start-up and Release Controller

This block sits between the reset sequencer and the core clock tree. Once system reset is released, it decides when a clock may be handed to the core and which source that clock comes from. The choice depends on the selected source. An external digital clock goes out at once. A crystal must first show a fixed number of oscillator edges. The internal RC sources wait for their ready flags. Any source that runs through the PLL also waits for lock. The start-up timing runs on its own and does not depend on the reset delay chain.

Two options change this behaviour. With fast boot enabled, the core is clocked from the internal fast RC as soon as that oscillator is ready, and the block moves to the primary source when the primary's own start-up completes. With the clock monitor enabled, the block watches the oscillator edge input from the moment reset is released. If no edge arrives within a parameterized number of reference cycles, the block falls back to the fast RC and raises a sticky clock-fail trap. Every register runs on an always-running reference clock. The oscillator edge input is a single-cycle pulse that has already been brought into that clock domain.

Top module: `clkrel_ctrl`

## Requirements
- R1: Before the first `rst_release` pulse after reset, `clk_valid` is 0, `active_src` is 0 (none) and `clk_fail_trap` is 0, whatever the other inputs do.
- R2: With `src_sel` = 0 (external clock, no PLL), the primary source (`active_src` = 1) is released within four cycles of the `rst_release` pulse.
- R3: With `src_sel` = 2 or 7 (crystal counted sources), the primary is not released until `OST_CYCLES` oscillator edges have been counted after the restart. It is released within a few cycles of the last counted edge.
- R4: With `src_sel` = 1, 3 or 5 (PLL variants of external, crystal and fast RC), the primary is released only once the base condition of the source is met and `pll_lock` is also high.
- R5: With `src_sel` = 4 the primary waits for `fast_rc_ready`. With `src_sel` = 6 it waits for `slow_rc_ready`.
- R6: With `fast_boot_en` high, `active_src` becomes 2 (fast RC) once `fast_rc_ready` is high and the primary is not yet ready. It changes to 1 when the primary start-up completes.
- R7: A `rst_release` pulse or a change of `src_sel` after arming is a restart. On the next cycle `active_src` is 0 and `clk_valid` is 0, and every start-up count and lock wait begins again from zero.
- R8: With `mon_en` high and an oscillator-based source (`src_sel` 0, 1, 2, 3 or 7), a gap of `FAIL_TICKS` reference cycles with no `osc_edge` switches `active_src` to 2 (if `fast_rc_ready`) and sets `clk_fail_trap`. Edges arriving regularly never cause a failure.
- R9: `clk_fail_trap` stays set, across restarts as well, until `trap_clr` is pulsed. A clear takes effect on the next cycle.
- R10: With `mon_en` low, `clk_fail_trap` never rises, however long the oscillator is silent.
- R11: `active_src` only ever takes the values 0, 1 or 2, and `clk_valid` is 1 exactly when `active_src` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_release | input | 1 | Single-cycle pulse marking system reset release |
| src_sel | input | 3 | Clock source code (0 ext, 1 ext+PLL, 2 crystal, 3 crystal+PLL, 4 fast RC, 5 fast RC+PLL, 6 slow RC, 7 low-frequency crystal) |
| fast_boot_en | input | 1 | Start on the fast RC, then switch to the primary |
| mon_en | input | 1 | Enable the clock monitor |
| osc_edge | input | 1 | Synchronized one-cycle pulse per oscillator period |
| pll_lock | input | 1 | PLL lock indication |
| fast_rc_ready | input | 1 | Fast RC start-up complete |
| slow_rc_ready | input | 1 | Slow RC start-up complete |
| trap_clr | input | 1 | Clears the clock-fail trap |
| clk_valid | output | 1 | A clock is released to the core |
| active_src | output | 2 | 0 none, 1 primary, 2 fast RC |
| clk_fail_trap | output | 1 | Sticky clock-fail trap |

## Verification
The assertions assume that `osc_edge` is a clean single-cycle pulse in the reference domain, and that `pll_lock` and the ready flags do not fall once they have risen within a run. The oscillator-count property also assumes that a restart is signalled either by a pulse or by a visible change of `src_sel`. The stimulus follows these rules. It toggles the oscillator pulse on alternate cycles or holds it silent, raises each ready and lock flag only once per scenario, and changes the source code only together with a release pulse or as a deliberate restart.

// File: rtl/clkrel_pkg.sv
package clkrel_pkg;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_PRI  = 2'd1,
      ACT_FAST = 2'd2
   } act_e;

   typedef enum logic [1:0] {
      BASE_DIRECT,
      BASE_XTAL,
      BASE_FASTRC,
      BASE_SLOWRC
   } base_e;

   function automatic base_e base_of(input logic [2:0] s);
      case (s)
         3'd0, 3'd1:       return BASE_DIRECT;
         3'd2, 3'd3, 3'd7: return BASE_XTAL;
         3'd4, 3'd5:       return BASE_FASTRC;
         default:          return BASE_SLOWRC;
      endcase
   endfunction

   function automatic logic uses_pll(input logic [2:0] s);
      return (s == 3'd1) || (s == 3'd3) || (s == 3'd5);
   endfunction

   function automatic logic has_osc(input logic [2:0] s);
      return (base_of(s) == BASE_DIRECT) || (base_of(s) == BASE_XTAL);
   endfunction

endpackage

// File: rtl/clkrel_startup.sv
module clkrel_startup
   import clkrel_pkg::*;
#(
   parameter int OST_CYCLES = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       armed,
   input  logic [2:0] src_sel,
   input  logic       osc_edge,
   input  logic       pll_lock,
   input  logic       fast_rc_ready,
   input  logic       slow_rc_ready,
   output logic       prim_done
);
   localparam int CW = $clog2(OST_CYCLES + 1);

   logic [CW-1:0] xcnt;
   logic          xdone;
   logic          base_ok;
   logic          base_hold;
   logic          lock_ok;
   base_e         kind;

   assign kind    = base_of(src_sel);
   assign xdone   = (xcnt == CW'(OST_CYCLES));
   assign lock_ok = !uses_pll(src_sel) || pll_lock;

   always_comb begin
      unique case (kind)
         BASE_DIRECT: base_ok = 1'b1;
         BASE_XTAL:   base_ok = xdone;
         BASE_FASTRC: base_ok = fast_rc_ready;
         default:     base_ok = slow_rc_ready;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xcnt      <= '0;
         base_hold <= 1'b0;
         prim_done <= 1'b0;
      end else if (restart) begin
         xcnt      <= '0;
         base_hold <= 1'b0;
         prim_done <= 1'b0;
      end else if (armed) begin
         if (kind == BASE_XTAL && osc_edge && !xdone)
            xcnt <= xcnt + CW'(1);
         base_hold <= base_hold | base_ok;
         if ((base_hold || base_ok) && lock_ok)
            prim_done <= 1'b1;
      end
   end

endmodule

// File: rtl/clkrel_mon.sv
module clkrel_mon #(
   parameter int FAIL_TICKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic enable,
   input  logic osc_edge,
   output logic failed,
   output logic fail_pulse
);
   localparam int GW = $clog2(FAIL_TICKS + 1);

   logic [GW-1:0] gap;
   logic          hit;

   assign hit = !osc_edge && !failed && (gap == GW'(FAIL_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap        <= '0;
         failed     <= 1'b0;
         fail_pulse <= 1'b0;
      end else if (restart) begin
         gap        <= '0;
         failed     <= 1'b0;
         fail_pulse <= 1'b0;
      end else if (!enable) begin
         gap        <= '0;
         fail_pulse <= 1'b0;
      end else begin
         fail_pulse <= hit;
         failed     <= failed | hit;
         if (osc_edge)
            gap <= '0;
         else if (gap != GW'(FAIL_TICKS))
            gap <= gap + GW'(1);
      end
   end

endmodule

// File: rtl/clkrel_arb.sv
module clkrel_arb
   import clkrel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       armed,
   input  logic       fast_boot_en,
   input  logic       fast_rc_ready,
   input  logic       prim_done,
   input  logic       failed,
   input  logic       fail_pulse,
   input  logic       trap_clr,
   output logic [1:0] active_src,
   output logic       clk_valid,
   output logic       trap
);
   act_e nxt;
   act_e act_q;

   always_comb begin
      if (restart || !armed)
         nxt = ACT_NONE;
      else if (failed)
         nxt = fast_rc_ready ? ACT_FAST : ACT_NONE;
      else if (prim_done)
         nxt = ACT_PRI;
      else if (fast_boot_en && fast_rc_ready)
         nxt = ACT_FAST;
      else
         nxt = ACT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= ACT_NONE;
         clk_valid <= 1'b0;
         trap      <= 1'b0;
      end else begin
         act_q     <= nxt;
         clk_valid <= (nxt != ACT_NONE);
         trap      <= fail_pulse | (trap & !trap_clr);
      end
   end

   assign active_src = act_q;

endmodule

// File: rtl/clkrel_ctrl.sv
module clkrel_ctrl
   import clkrel_pkg::*;
#(
   parameter int OST_CYCLES = 1024,
   parameter int FAIL_TICKS = 64,
   parameter bit MONITOR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rst_release,
   input  logic [2:0] src_sel,
   input  logic       fast_boot_en,
   input  logic       mon_en,
   input  logic       osc_edge,
   input  logic       pll_lock,
   input  logic       fast_rc_ready,
   input  logic       slow_rc_ready,
   input  logic       trap_clr,
   output logic       clk_valid,
   output logic [1:0] active_src,
   output logic       clk_fail_trap
);
   if (OST_CYCLES < 1) begin : g_bad_ost
      $error("OST_CYCLES must be at least 1");
   end
   if (FAIL_TICKS < 2) begin : g_bad_fail
      $error("FAIL_TICKS must be at least 2");
   end

   logic       armed;
   logic [2:0] sel_q;
   logic       restart;
   logic       prim_done;
   logic       failed;
   logic       fail_pulse;
   logic       mon_on;

   assign restart = rst_release || (armed && (src_sel != sel_q));
   assign mon_on  = armed && mon_en && has_osc(src_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         sel_q <= '0;
      end else begin
         armed <= armed | rst_release;
         sel_q <= src_sel;
      end
   end

   clkrel_startup #(.OST_CYCLES(OST_CYCLES)) u_start (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart       (restart),
      .armed         (armed),
      .src_sel       (src_sel),
      .osc_edge      (osc_edge),
      .pll_lock      (pll_lock),
      .fast_rc_ready (fast_rc_ready),
      .slow_rc_ready (slow_rc_ready),
      .prim_done     (prim_done)
   );

   if (MONITOR_EN) begin : g_mon
      clkrel_mon #(.FAIL_TICKS(FAIL_TICKS)) u_mon (
         .clk        (clk),
         .rst_n      (rst_n),
         .restart    (restart),
         .enable     (mon_on),
         .osc_edge   (osc_edge),
         .failed     (failed),
         .fail_pulse (fail_pulse)
      );
   end else begin : g_nomon
      assign failed     = 1'b0;
      assign fail_pulse = 1'b0;
   end

   clkrel_arb u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart       (restart),
      .armed         (armed),
      .fast_boot_en  (fast_boot_en),
      .fast_rc_ready (fast_rc_ready),
      .prim_done     (prim_done),
      .failed        (failed),
      .fail_pulse    (fail_pulse),
      .trap_clr      (trap_clr),
      .active_src    (active_src),
      .clk_valid     (clk_valid),
      .trap          (clk_fail_trap)
   );

endmodule

// File: rtl/clkrel_ctrl_chk.sv
module clkrel_ctrl_chk #(
   parameter int OST_CYCLES = 1024
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rst_release,
   input logic [2:0] src_sel,
   input logic       mon_en,
   input logic       osc_edge,
   input logic       trap_clr,
   input logic       armed,
   input logic       clk_valid,
   input logic [1:0] active_src,
   input logic       clk_fail_trap
);
   localparam int EW = $clog2(OST_CYCLES + 1);

   logic [EW-1:0] ecnt;
   logic [2:0]    selc;
   logic          rs;
   logic          xtal_src;

   assign rs       = rst_release || (armed && (src_sel != selc));
   assign xtal_src = (src_sel == 3'd2) || (src_sel == 3'd3) || (src_sel == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecnt <= '0;
         selc <= '0;
      end else begin
         selc <= src_sel;
         if (rs)
            ecnt <= '0;
         else if (armed && osc_edge && ecnt != EW'(OST_CYCLES))
            ecnt <= ecnt + EW'(1);
      end
   end

   assert_idle_until_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!clk_valid && active_src == 2'd0 && !clk_fail_trap));

   assert_restart_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_release |=> (!clk_valid && active_src == 2'd0));

   assert_xtal_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_src == 2'd1 && xtal_src && !rs) |-> (ecnt == EW'(OST_CYCLES)));

   assert_trap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_fail_trap && !trap_clr) |=> clk_fail_trap);

   assert_fail_leaves_primary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_fail_trap) |-> (active_src != 2'd1));

   assert_off_no_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!mon_en && !$past(mon_en) && !clk_fail_trap) |=> !clk_fail_trap);

   assert_legal_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      active_src != 2'd3);

endmodule

bind clkrel_ctrl clkrel_ctrl_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rst_release   (rst_release),
   .src_sel       (src_sel),
   .mon_en        (mon_en),
   .osc_edge      (osc_edge),
   .trap_clr      (trap_clr),
   .armed         (armed),
   .clk_valid     (clk_valid),
   .active_src    (active_src),
   .clk_fail_trap (clk_fail_trap)
);

// File: tb/clkrel_ctrl_test.sv
`timescale 1ns/1ps
module clkrel_ctrl_test;
   localparam int OSTN = 1024;
   localparam int FT   = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rst_release = 1'b0;
   logic [2:0] src_sel = 3'd0;
   logic       fast_boot_en = 1'b0;
   logic       mon_en = 1'b0;
   logic       osc_edge = 1'b0;
   logic       pll_lock = 1'b0;
   logic       fast_rc_ready = 1'b0;
   logic       slow_rc_ready = 1'b0;
   logic       trap_clr = 1'b0;
   logic       osc_run = 1'b0;
   logic       clk_valid;
   logic [1:0] active_src;
   logic       clk_fail_trap;

   clkrel_ctrl #(.OST_CYCLES(OSTN), .FAIL_TICKS(FT), .MONITOR_EN(1'b1)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .rst_release   (rst_release),
      .src_sel       (src_sel),
      .fast_boot_en  (fast_boot_en),
      .mon_en        (mon_en),
      .osc_edge      (osc_edge),
      .pll_lock      (pll_lock),
      .fast_rc_ready (fast_rc_ready),
      .slow_rc_ready (slow_rc_ready),
      .trap_clr      (trap_clr),
      .clk_valid     (clk_valid),
      .active_src    (active_src),
      .clk_fail_trap (clk_fail_trap)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      logic [3:0] tup;
      int         lo;
      int         hi;
      string      req;
   } exp_t;

   exp_t       q[$];
   int         t0 = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         mon_go = 1'b0;
   logic [3:0] prev = 4'd0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic expect_evt(input logic [1:0] a, input logic t, input int lo,
                             input int hi, input string req);
      exp_t e;
      e.tup = {a, (a != 2'd0), t};
      e.lo  = lo;
      e.hi  = hi;
      e.req = req;
      q.push_back(e);
   endtask

   // scoreboard monitor: every output change must match the next expected item
   always @(negedge clk) begin
      if (mon_go) begin
         logic [3:0] cur;
         cur = {active_src, clk_valid, clk_fail_trap};
         if (cur !== prev) begin
            if (q.size() == 0) begin
               check(1'b0, "R11", "unexpected output change", int'(cur), int'(prev));
            end else begin
               exp_t e;
               int   d;
               e = q.pop_front();
               d = cyc - t0;
               check(cur == e.tup, e.req, "outputs {act,valid,trap}", int'(cur), int'(e.tup));
               check(d >= e.lo && d <= e.hi, e.req, "latency", d, e.lo);
            end
            prev = cur;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         osc_edge = osc_run ? ~osc_edge : 1'b0;
      end
   end

   task automatic start(input logic [2:0] s);
      @(negedge clk);
      src_sel     = s;
      rst_release = 1'b1;
      t0          = cyc;
      @(negedge clk);
      rst_release = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string req);
      int n = 0;
      while (q.size() != 0 && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check(q.size() == 0, req, "expected events still pending", q.size(), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(clk_valid == 1'b0, "R1", "clk_valid after reset", int'(clk_valid), 0);
      check(active_src == 2'd0, "R1", "active_src after reset", int'(active_src), 0);
      check(clk_fail_trap == 1'b0, "R1", "trap after reset", int'(clk_fail_trap), 0);
      prev   = {active_src, clk_valid, clk_fail_trap};
      mon_go = 1'b1;
      // R1: no release without the release pulse, even with everything ready
      fast_rc_ready = 1'b1;
      slow_rc_ready = 1'b1;
      fast_boot_en  = 1'b1;
      osc_run       = 1'b1;
      wait_cyc(30);
      check(clk_valid == 1'b0, "R1", "clk_valid before release", int'(clk_valid), 0);
      fast_rc_ready = 1'b0;
      fast_boot_en  = 1'b0;

      // R2: external clock, released at once
      expect_evt(2'd1, 1'b0, 2, 4, "R2");
      start(3'd0);
      drain("R2");

      // R5: fast RC source waits for its ready flag
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      start(3'd4);
      drain("R7");
      wait_cyc(30);
      check(clk_valid == 1'b0, "R5", "held before fast RC ready", int'(clk_valid), 0);
      expect_evt(2'd1, 1'b0, 1, 3, "R5");
      @(negedge clk);
      fast_rc_ready = 1'b1;
      t0 = cyc;
      drain("R5");

      // R5: slow RC source
      slow_rc_ready = 1'b0;
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      start(3'd6);
      drain("R7");
      wait_cyc(25);
      check(active_src == 2'd0, "R5", "held before slow RC ready", int'(active_src), 0);
      expect_evt(2'd1, 1'b0, 1, 3, "R5");
      @(negedge clk);
      slow_rc_ready = 1'b1;
      t0 = cyc;
      drain("R5");

      // R6/R3/R4: crystal with PLL under fast boot
      fast_boot_en = 1'b1;
      pll_lock     = 1'b0;
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      expect_evt(2'd2, 1'b0, 2, 3, "R6");
      start(3'd3);
      drain("R6");
      wait_cyc(2200);
      check(active_src == 2'd2, "R4", "still on fast RC without lock", int'(active_src), 2);
      expect_evt(2'd1, 1'b0, 1, 3, "R4");
      @(negedge clk);
      pll_lock = 1'b1;
      t0 = cyc;
      drain("R4");

      // R7/R3: change of select restarts the crystal count from zero
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      expect_evt(2'd2, 1'b0, 2, 3, "R6");
      expect_evt(2'd1, 1'b0, 2040, 2060, "R3");
      @(negedge clk);
      src_sel = 3'd2;
      t0 = cyc;
      drain("R3");

      // R8: silent crystal with monitor on falls back and traps
      osc_run      = 1'b0;
      mon_en       = 1'b1;
      fast_boot_en = 1'b0;
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      expect_evt(2'd2, 1'b1, FT, FT + 4, "R8");
      start(3'd2);
      drain("R8");
      // R9: trap holds, then clears
      wait_cyc(20);
      check(clk_fail_trap == 1'b1, "R9", "trap held", int'(clk_fail_trap), 1);
      expect_evt(2'd2, 1'b0, 1, 2, "R9");
      @(negedge clk);
      trap_clr = 1'b1;
      t0 = cyc;
      @(negedge clk);
      trap_clr = 1'b0;
      drain("R9");

      // R10: monitor off, silent oscillator never traps
      mon_en = 1'b0;
      expect_evt(2'd0, 1'b0, 1, 2, "R7");
      start(3'd2);
      drain("R7");
      wait_cyc(200);
      check(clk_fail_trap == 1'b0, "R10", "trap with monitor off", int'(clk_fail_trap), 0);
      check(active_src == 2'd0, "R3", "crystal without edges held", int'(active_src), 0);

      // R8: regular edges never fail, then loss of edges fails
      mon_en  = 1'b1;
      osc_run = 1'b1;
      expect_evt(2'd1, 1'b0, 2, 4, "R2");
      start(3'd0);
      drain("R2");
      wait_cyc(300);
      check(clk_fail_trap == 1'b0, "R8", "trap with regular edges", int'(clk_fail_trap), 0);
      check(active_src == 2'd1, "R8", "primary kept with regular edges", int'(active_src), 1);
      expect_evt(2'd2, 1'b1, FT, FT + 5, "R8");
      @(negedge clk);
      osc_run = 1'b0;
      t0 = cyc;
      drain("R8");

      mon_go = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule